// File: doc/BRIEF.md
# Floppy Drive Control Register Decode

This block holds the two control registers of a two-drive floppy controller and turns them into the drive-facing control pins. A byte-wide host register bus writes a drive-control register and a tape-assignment register, both within a small window above a base address of 0x3F0. From the drive-control register the block produces active-low motor-on and drive-select pins and a combined DMA/interrupt enable. From the tape register it reports which drive, if any, has tape support. The data path, the FIFO, the command sequencer and the DMA engine are outside this block.

A single mode input selects the operating style. In AT style (which also covers Model 30 behaviour) bit 3 of the drive-control register gates DMA and interrupts. In PS/2 style they are always enabled. Bit 2 of the drive-control register is an active-low software reset. A small two-state machine tracks it. After a hardware reset the machine sits in `DOR_HELD`. A write with bit 2 set moves it to `DOR_RUN` (transition *release*). A write with bit 2 clear moves it back to `DOR_HELD` from either state (transition *soft_reset*) and clears every other drive-control bit. In `DOR_RUN`, a write with bit 2 set stays in `DOR_RUN` (transition *load*).

Reads are combinational from the address. Alongside the data, the block gives a per-bit drive mask: a bit whose mask is 0 is not driven, which is the high-impedance marker.

Top module: `fdc_ctrl_decode`

## Requirements
- R1: After hardware reset both registers read 0x00, `mtr_n` and `ds_n` are 2'b11, `tape_sel` is 2'b00 and `dma_irq_en` equals `mode_ps2`.
- R2: A write at address 0x3F2 with data bit 2 = 1 stores the full byte in the drive-control register on that clock edge. A read at 0x3F2 returns the byte with `rd_oe` = 8'hFF.
- R3: `mtr_n[0]` is the inverse of drive-control bit 4 and `mtr_n[1]` is the inverse of bit 5.
- R4: `ds_n[0]` is 0 only when bits 1:0 = 2'b00 and bit 4 = 1. `ds_n[1]` is 0 only when bits 1:0 = 2'b01 and bit 5 = 1. In every other case both stay 1, and at most one is 0.
- R5: Drive-control bits 7 and 6 are stored and read back but affect no output pin.
- R6: With `mode_ps2` = 0, `dma_irq_en` equals drive-control bit 3. With `mode_ps2` = 1, it is 1 regardless of bit 3.
- R7: A write at 0x3F2 with data bit 2 = 0 sets the whole drive-control register to 0x00 and leaves the tape register unchanged.
- R8: A write at 0x3F3 stores data bits 1:0 in the tape register and ignores bits 7:2. `tape_sel` gives the tape drive (00 none, 01 drive 1, 10 drive 2, 11 drive 3; drive 0 is never the tape drive). A read at 0x3F3 returns bits 1:0 with `rd_oe` = 8'h03 and data bits 7:2 = 0.
- R9: A write at any other address changes neither register. A read at any other address gives `rd_oe` = 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| mode_ps2 | input | 1 | 1 = PS/2 style, 0 = AT/Model 30 style |
| addr | input | 12 | Host register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| rd_oe | output | 8 | Per-bit drive mask for `rd_data` (0 = not driven) |
| mtr_n | output | 2 | Active-low motor-on, drives 0 and 1 |
| ds_n | output | 2 | Active-low drive-select, drives 0 and 1 |
| dma_irq_en | output | 1 | DMA and interrupt enable |
| tape_sel | output | 2 | Drive assigned tape support (00 = none) |

## Verification
The bench writes all 256 drive-control byte values in each mode and computes the pins from the bits. This separates the select-with-motor pairing from a plain select decode. It also shows whether the upper motor bits leak onto a pin, whether the mode overrides bit 3, and whether bit 2 clears the rest of the register. The tape register is set before that sweep and read after it, which tells a software reset apart from a hardware reset. All four tape codes are written with the upper bits set, which exposes a failure to mask the undriven readback bits. Writes to neighbouring addresses check that the address decode is exact.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    typedef enum logic {
        DOR_HELD = 1'b0,
        DOR_RUN  = 1'b1
    } dor_state_e;

    localparam int DOR_OFFSET = 2;
    localparam int TDR_OFFSET = 3;
    localparam int SWRST_BIT  = 2;
    localparam int DMA_BIT    = 3;
    localparam int MOTOR_LSB  = 4;
endpackage

// File: rtl/fdc_dor_reg.sv
module fdc_dor_reg
    import fdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] dor_q
);
    dor_state_e state_q, state_d;
    logic [4:0] hi_q;
    logic [1:0] lo_q;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (state_q)
                DOR_HELD: state_d = wdata[SWRST_BIT] ? DOR_RUN : DOR_HELD;
                DOR_RUN:  state_d = wdata[SWRST_BIT] ? DOR_RUN : DOR_HELD;
                default:  state_d = DOR_HELD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DOR_HELD;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (wr) begin
                if (wdata[SWRST_BIT]) begin
                    hi_q <= wdata[7:3];
                    lo_q <= wdata[1:0];
                end else begin
                    hi_q <= '0;
                    lo_q <= '0;
                end
            end
        end
    end

    always_comb begin
        dor_q = {hi_q, (state_q == DOR_RUN), lo_q};
    end

    assert_swrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[SWRST_BIT]) |=> (dor_q == 8'h00));

    assert_load_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[SWRST_BIT]) |=> (dor_q == $past(wdata)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(dor_q));
endmodule

// File: rtl/fdc_tape_reg.sv
module fdc_tape_reg #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wsel,
    output logic [SEL_W-1:0] tape_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  tape_q <= '0;
        else if (wr) tape_q <= wsel;
    end

    assert_tape_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(tape_q));
endmodule

// File: rtl/fdc_drive_decode.sv
module fdc_drive_decode #(
    parameter int NUM_DRIVES = 2,
    parameter int SEL_W      = 2
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_DRIVES-1:0] motor,
    output logic [NUM_DRIVES-1:0] mtr_n,
    output logic [NUM_DRIVES-1:0] ds_n
);
    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
        always_comb begin
            mtr_n[i] = ~motor[i];
            ds_n[i]  = ~((sel == SEL_W'(i)) && motor[i]);
        end
    end

    always_comb begin
        assert_ds_onehot_R4: assert ($onehot0(~ds_n));
        for (int k = 0; k < NUM_DRIVES; k++) begin
            assert_ds_needs_motor_R4: assert (ds_n[k] || !mtr_n[k]);
        end
    end
endmodule

// File: rtl/fdc_ctrl_decode.sv
module fdc_ctrl_decode
    import fdc_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [11:0]     BASE       = 12'h3F0,
    parameter int              NUM_DRIVES = 2,
    parameter int              SEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ps2,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic [7:0]        rd_oe,
    output logic [1:0]        mtr_n,
    output logic [1:0]        ds_n,
    output logic              dma_irq_en,
    output logic [1:0]        tape_sel
);
    localparam logic [ADDR_W-1:0] DOR_ADDR = ADDR_W'(BASE) + ADDR_W'(DOR_OFFSET);
    localparam logic [ADDR_W-1:0] TDR_ADDR = ADDR_W'(BASE) + ADDR_W'(TDR_OFFSET);
    localparam logic [7:0]        TDR_OE   = 8'((1 << SEL_W) - 1);

    logic             dor_hit, tdr_hit;
    logic [7:0]       dor_q;
    logic [SEL_W-1:0] tape_q;

    always_comb begin
        dor_hit = (addr == DOR_ADDR);
        tdr_hit = (addr == TDR_ADDR);
    end

    fdc_dor_reg u_dor (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && dor_hit),
        .wdata (wdata),
        .dor_q (dor_q)
    );

    fdc_tape_reg #(.SEL_W(SEL_W)) u_tape (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_en && tdr_hit),
        .wsel   (wdata[SEL_W-1:0]),
        .tape_q (tape_q)
    );

    fdc_drive_decode #(.NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W)) u_dec (
        .sel   (dor_q[SEL_W-1:0]),
        .motor (dor_q[MOTOR_LSB +: NUM_DRIVES]),
        .mtr_n (mtr_n),
        .ds_n  (ds_n)
    );

    always_comb begin
        dma_irq_en = mode_ps2 | dor_q[DMA_BIT];
        tape_sel   = tape_q;
        rd_data    = 8'h00;
        rd_oe      = 8'h00;
        if (dor_hit) begin
            rd_data = dor_q;
            rd_oe   = 8'hFF;
        end else if (tdr_hit) begin
            rd_data = 8'(tape_q);
            rd_oe   = TDR_OE;
        end
    end

    assert_ps2_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ps2 |-> dma_irq_en);

    assert_tdr_upper_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_hit |-> (rd_oe == 8'h03 && rd_data[7:2] == 6'b0));

    assert_other_write_keeps_tape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tdr_hit) |=> $stable(tape_sel));
endmodule

// File: tb/test_fdc_ctrl_decode.sv
module test_fdc_ctrl_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ps2 = 1'b0;
    logic [11:0] addr = 12'h000;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rd_data, rd_oe;
    logic [1:0]  mtr_n, ds_n, tape_sel;
    logic        dma_irq_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fdc_ctrl_decode i_fdc_ctrl_decode (
        .clk(clk), .rst_n(rst_n), .mode_ps2(mode_ps2), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rd_data(rd_data), .rd_oe(rd_oe),
        .mtr_n(mtr_n), .ds_n(ds_n), .dma_irq_en(dma_irq_en), .tape_sel(tape_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [7:0] exp_d,
                          input logic [7:0] exp_oe, input string req);
        addr = a;
        #1;
        chk(rd_data == exp_d, req, rd_data, exp_d);
        chk(rd_oe == exp_oe, req, rd_oe, exp_oe);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] stored;
        logic [1:0] exp_ds;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ds_n == 2'b11, "R1 ds_n", ds_n, 3);
        chk(mtr_n == 2'b11, "R1 mtr_n", mtr_n, 3);
        chk(dma_irq_en == 1'b0, "R1 dma", dma_irq_en, 0);
        chk(tape_sel == 2'b00, "R1 tape", tape_sel, 0);
        rd_chk(12'h3F2, 8'h00, 8'hFF, "R1 dor read");
        rd_chk(12'h3F3, 8'h00, 8'h03, "R1 tdr read");
        rst_n = 1'b1;
        @(negedge clk);

        // R8: tape register codes with junk in upper bits
        for (int t = 0; t < 4; t++) begin
            bus_wr(12'h3F3, 8'hFC | 8'(t));
            chk(tape_sel == 2'(t), "R8 tape_sel", tape_sel, t);
            rd_chk(12'h3F3, 8'(t), 8'h03, "R8 tdr read");
        end
        bus_wr(12'h3F3, 8'h02);

        // R2..R7: sweep all drive-control values in both modes
        for (int m = 0; m < 2; m++) begin
            mode_ps2 = 1'(m);
            for (int v = 0; v < 256; v++) begin
                bus_wr(12'h3F2, 8'(v));
                stored = v[2] ? 8'(v) : 8'h00;
                exp_ds[0] = !(stored[1:0] == 2'b00 && stored[4]);
                exp_ds[1] = !(stored[1:0] == 2'b01 && stored[5]);
                rd_chk(12'h3F2, stored, 8'hFF, "R2 R5 R7 dor read");
                chk(mtr_n == ~stored[5:4], "R3 mtr_n", mtr_n, ~stored[5:4]);
                chk(ds_n == exp_ds, "R4 R5 ds_n", ds_n, exp_ds);
                chk(dma_irq_en == (m == 1 || stored[3]), "R6 dma", dma_irq_en,
                    (m == 1 || stored[3]) ? 1 : 0);
            end
        end
        // R7: tape register kept across soft resets
        chk(tape_sel == 2'b10, "R7 tape kept", tape_sel, 2);

        // R9: writes to neighbouring addresses
        mode_ps2 = 1'b0;
        bus_wr(12'h3F2, 8'h1C);
        bus_wr(12'h3F1, 8'h00);
        bus_wr(12'h3F4, 8'h03);
        bus_wr(12'h2F2, 8'h00);
        bus_wr(12'h2F3, 8'h01);
        rd_chk(12'h3F2, 8'h1C, 8'hFF, "R9 dor unchanged");
        rd_chk(12'h3F3, 8'h02, 8'h03, "R9 tdr unchanged");
        rd_chk(12'h3F1, 8'h00, 8'h00, "R9 other read");
        chk(ds_n == 2'b10, "R9 ds_n", ds_n, 2);
        chk(tape_sel == 2'b10, "R9 tape", tape_sel, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule